// File: doc/BRIEF.md
# Overwriting Result Queue with Byte-Serial Readout

This block sits between a converter and a host serial port. Each time the converter asserts a valid strobe, the block stores the 12-bit result in a small queue that holds sixteen entries. When the queue is full, a new result never stalls the producer. Instead the oldest stored result that is not being read is thrown away to make room.

The host reads results through a four-wire style port: an active-low select, a serial clock that idles low, and one serial data line. Each select frame delivers exactly one byte, and a result takes two frames. The first frame carries the upper byte, which is four zero bits followed by the top four result bits. The second frame carries the lower eight bits. A result leaves the queue only after its second byte has been clocked out completely.

All port activity is sampled in the system clock domain, so the serial clock must run several times slower than the system clock.

Top module: `rf_result_fifo_spi`

## Requirements
- R1: After synchronous reset the queue is empty, the next frame delivers the upper byte of a result, and the serial output is 0.
- R2: Up to 16 results are kept and read back in arrival order.
- R3: A result written while 16 are stored and no readout is in progress discards the oldest stored result and is appended as the newest.
- R4: A result v is sent as two bytes. The first is v[11:8] with four zero bits above it (bits 7..4 = 0). The second is v[7:0].
- R5: The byte is sent most significant bit first. The first bit is on the output shortly after the select falls. Each later bit appears after a serial-clock falling edge, so the host samples on rising edges.
- R6: A frame started while the queue is empty outputs 0 on every bit and consumes nothing.
- R7: A result is removed only after both of its bytes have completed. After the upper byte has been read, the next frame delivers the lower byte of that same result.
- R8: A frame that ends with fewer than 8 rising serial-clock edges does not count as a read, and the same byte is presented again in the next frame.
- R9: While a result's readout is in progress (upper byte read, lower byte not yet completed), a write into a full queue keeps that result and discards the oldest of the other entries instead.
- R10: A frame moves to at most one new byte. Serial-clock edges beyond the eighth shift out 0 bits and do not advance the readout.
- R11: While the select is high, the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| res_vld | input | 1 | One-cycle strobe: res_word is a new result |
| res_word | input | 12 | Result value |
| sel_n | input | 1 | Frame select from host, active low |
| ser_clk | input | 1 | Serial clock from host, idle low |
| ser_out | output | 1 | Serial data to host |

## Verification
A wrong entry count or a wrong shift position in the storage array shows up directly as the wrong byte value in a later frame, at the latest after the queue has been drained. That is at most 32 frames after the fault. A wrong byte-phase bit produces a byte from the wrong half, or a result that appears twice or goes missing, in the very next frame. A lock that releases at the wrong time shows only when a full queue receives a write during a split readout. For that reason the sweep drives that exact case and checks the whole drained sequence.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_e;

  // Select which half of a 16-bit padded result goes out next.
  function automatic logic [7:0] pick_byte(logic [15:0] padded, phase_e ph);
    return (ph == PH_HI) ? padded[15:8] : padded[7:0];
  endfunction

  function automatic phase_e flip(phase_e ph);
    return (ph == PH_HI) ? PH_LO : PH_HI;
  endfunction
endpackage

// File: rtl/rf_edges.sv
module rf_edges (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic ser_clk,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sk_rise,
  output logic sk_fall
);
  logic cs_q, sk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      sk_q <= 1'b0;
    end else begin
      cs_q <= sel_n;
      sk_q <= ser_clk;
    end
  end

  assign cs_act  = ~cs_q;
  assign cs_fall = cs_q & ~sel_n;
  assign cs_rise = ~cs_q & sel_n;
  assign sk_rise = ~sk_q & ser_clk;
  assign sk_fall = sk_q & ~ser_clk;
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         lock,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          full;
  logic          drop_any;
  logic          drop_second;
  logic [CW-1:0] cnt_kept;

  assign full        = (cnt == CW'(DEPTH));
  assign empty       = (cnt == '0);
  assign drop_any    = pop | (push & full);
  // Overwrite while the head is being read: remove entry 1, not entry 0.
  assign drop_second = ~pop & lock;
  assign cnt_kept    = cnt - CW'(drop_any);
  assign head        = mem[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic shift_here;
    if (i == 0) begin : g_first
      assign shift_here = drop_any & ~drop_second;
    end else begin : g_rest
      assign shift_here = drop_any;
    end
    always_ff @(posedge clk) begin
      if (push && cnt_kept == CW'(i))
        mem[i] <= push_data;
      else if (shift_here && i < DEPTH - 1)
        mem[i] <= mem[(i < DEPTH - 1) ? i + 1 : i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_kept + CW'(push);
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r3_full_stays_full: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> full);
  a_r9_head_kept: assert property (@(posedge clk) disable iff (rst)
    (lock && !pop) |=> head == $past(head));
endmodule

// File: rtl/rf_shifter.sv
module rf_shifter
  import rf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_act,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         sk_rise,
  input  logic         sk_fall,
  input  logic [W-1:0] head,
  input  logic         empty,
  output logic         byte_done,
  output logic         pop,
  output logic         lock,
  output logic         sdo
);
  localparam int PADW = 16 - W;

  phase_e     phase;
  logic       busy;
  logic [3:0] bits;
  logic [7:0] sh;
  logic       mid;

  assign mid       = cs_act & ~cs_fall & ~cs_rise;
  assign byte_done = mid & busy & sk_rise & (bits == 4'd7);
  assign pop       = byte_done & (phase == PH_LO);
  assign lock      = busy | (phase == PH_LO);
  assign sdo       = cs_act & sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_HI;
      busy  <= 1'b0;
      bits  <= '0;
      sh    <= '0;
    end else if (cs_fall) begin
      sh   <= empty ? 8'h00 : pick_byte({{PADW{1'b0}}, head}, phase);
      busy <= ~empty;
      bits <= '0;
    end else if (cs_rise) begin
      busy <= 1'b0;
      bits <= '0;
    end else if (cs_act) begin
      if (sk_rise && bits < 4'd8) bits <= bits + 4'd1;
      if (sk_fall) sh <= {sh[6:0], 1'b0};
      if (byte_done) begin
        busy  <= 1'b0;
        phase <= flip(phase);
      end
    end
  end

  a_r10_bits_bound: assert property (@(posedge clk) disable iff (rst)
    bits <= 4'd8);
  a_r8_abort_keeps_phase: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !byte_done) |=> phase == $past(phase));
endmodule

// File: rtl/rf_result_fifo_spi.sv
module rf_result_fifo_spi #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         res_vld,
  input  logic [W-1:0] res_word,
  input  logic         sel_n,
  input  logic         ser_clk,
  output logic         ser_out
);
  logic cs_act, cs_fall, cs_rise, sk_rise, sk_fall;
  logic [W-1:0] head;
  logic empty, byte_done, pop, lock;

  rf_edges u_edges (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk),
    .cs_act(cs_act), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sk_rise(sk_rise), .sk_fall(sk_fall)
  );

  rf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst(rst), .push(res_vld), .push_data(res_word),
    .pop(pop), .lock(lock), .head(head), .empty(empty)
  );

  rf_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sk_rise(sk_rise), .sk_fall(sk_fall),
    .head(head), .empty(empty), .byte_done(byte_done), .pop(pop),
    .lock(lock), .sdo(ser_out)
  );

  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    !cs_act |-> !ser_out);
  a_r6_empty_frame_zero: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && empty) |=> !ser_out);
  a_r5_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sk_fall && !cs_fall) |=> (!cs_act || ser_out == $past(ser_out)));
  a_r7_done_in_frame: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> cs_act);
endmodule

// File: tb/rf_result_fifo_spi_bench.sv
module rf_result_fifo_spi_bench;
  localparam int DEPTH = 16;
  localparam int W     = 12;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_vld = 1'b0;
  logic [W-1:0] res_word = '0;
  logic sel_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int q[$];
  bit ph = 1'b0;

  always #2.5 clk = ~clk;

  rf_result_fifo_spi #(.DEPTH(DEPTH), .W(W)) u_rf_result_fifo_spi (
    .clk(clk), .rst(rst), .res_vld(res_vld), .res_word(res_word),
    .sel_n(sel_n), .ser_clk(ser_clk), .ser_out(ser_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_byte();
    if (q.size() == 0) return 0;
    return ph ? (q[0] % 256) : (q[0] / 256);
  endfunction

  task automatic model_read();
    if (q.size() != 0) begin
      if (ph) begin void'(q.pop_front()); ph = 1'b0; end
      else ph = 1'b1;
    end
  endtask

  task automatic push(input int v);
    @(negedge clk);
    res_vld = 1'b1;
    res_word = W'(v);
    @(negedge clk);
    res_vld = 1'b0;
    if (q.size() == DEPTH) begin
      if (ph) q.delete(1);
      else void'(q.pop_front());
    end
    q.push_back(v);
  endtask

  task automatic xfer(input int nclk, output logic [15:0] got);
    got = '0;
    @(negedge clk);
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nclk; b++) begin
      got = {got[14:0], ser_out};
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sel_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic read_byte(input string req);
    logic [15:0] got;
    int exp;
    exp = model_byte();
    xfer(8, got);
    check(req, int'(got[7:0]), exp);
    model_read();
  endtask

  task automatic drain(input string req);
    while (q.size() != 0) read_byte(req);
  endtask

  function automatic int pat(input int i);
    return (i * 419 + 1443) % 4096;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    check("R1 idle output", int'(ser_out), 0);
    // R6: empty frame reads zero
    read_byte("R6 empty frame");
    read_byte("R1 R6 still empty");

    // R11: idle output low with data stored
    push(12'hABC);
    repeat (3) @(negedge clk);
    check("R11 select high", int'(ser_out), 0);

    // R8: truncated frame, then full byte repeats the same upper byte
    xfer(4, got);
    check("R8 partial bits", int'(got[3:0]), model_byte() / 16);
    read_byte("R8 repeat after abort");
    // R7: after the upper byte, the lower byte of the same result follows
    push(12'h5E7);
    read_byte("R7 lower byte of head");
    read_byte("R4 second result upper");
    xfer(5, got);
    check("R8 abort on lower byte", int'(got[4:0]), model_byte() / 8);
    read_byte("R7 R8 lower byte again");
    read_byte("R6 empty after drain");

    // R2 R4 R5: fill and drain with a sweep of patterns
    for (int i = 0; i < DEPTH; i++) push(pat(i));
    drain("R2 R4 R5 order and format");
    read_byte("R6 empty after full drain");

    // R3: overflow while idle drops the oldest
    for (int i = 0; i < DEPTH + 3; i++) push(pat(i + 40));
    check("R3 head after overflow", q[0], pat(43));
    drain("R3 overflow contents");

    // R9: overflow during split readout keeps the head
    for (int i = 0; i < DEPTH; i++) push(pat(i + 80));
    read_byte("R9 upper byte");
    push(pat(200));
    push(pat(201));
    check("R9 head kept", q[0], pat(80));
    drain("R9 contents after locked overwrite");

    // R10: extra clocks shift zeros, one byte per frame
    push(12'hF3C);
    push(12'h0A5);
    xfer(12, got);
    check("R10 byte in long frame", int'(got[11:4]), 12'hF3C / 256);
    check("R10 trailing zeros", int'(got[3:0]), 0);
    model_read();
    drain("R10 following bytes");

    // R4: exhaustive upper-nibble sweep
    for (int i = 0; i < 16; i++) push(i * 256 + 255 - i);
    drain("R4 nibble sweep");

    // R1: synchronous reset empties and clears phase
    push(12'h123);
    push(12'h456);
    read_byte("R1 pre-reset upper");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    ph = 1'b0;
    read_byte("R1 empty after reset");
    push(12'h789);
    read_byte("R1 upper byte after reset");
    drain("R1 lower after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule